// File: doc/BRIEF.md
# Indexed-Clear Channel Flag Register

This block keeps one sticky flag per channel of a 64-channel DMA engine. The vector can hold interrupt requests, error indicators or error-interrupt enables. Hardware raises flags with a vector of per-channel set strobes. A flag stays set until software clears it.

Software clears flags through a byte-wide command register, not through a bitmap. The command field holds either the number of one channel or a request to clear every flag. The same small register bus presents the flag vector as two 32-bit words. Reads and writes complete in the cycle they are presented, with no wait states.

Address map (byte addresses, word aligned, the two low address bits are ignored): 0x0 holds channels 0 to 31, 0x4 holds channels 32 to 63, and 0x8 is the clear command, in byte lane 0.

Top module: `chan_flag_idxclr`

## Requirements
- R1: After reset every flag is zero, and reads of 0x0 and 0x4 return zero.
- R2: A set strobe high on channel n for one cycle sets flag n from the next edge on. The flag stays set until a clear reaches it.
- R3: A command write whose 7-bit field (bits 6:0 of byte lane 0 at 0x8) holds a value from 0 to 63 clears only the flag of that channel. All other flags keep their values.
- R4: A command write whose field holds a value from 64 to 127 (field bit 6 set) clears all 64 flags at once.
- R5: Bit 7 of the command byte is ignored. Commands that differ only in that bit act the same.
- R6: When a set strobe and a clear reach the same flag in the same cycle, the flag is set after that edge.
- R7: Read data at 0x0 bit i is the flag of channel i. Read data at 0x4 bit i is the flag of channel 32+i.
- R8: A read of 0x8 returns zero whatever was written there before.
- R9: Writes to 0x0 and 0x4 change no flag.
- R10: A write to 0x8 acts only when write strobe bit 0 is high. When bit 0 is low, the bytes in lanes 1 to 3 and the other strobe bits have no effect.
- R11: The clear takes effect on the edge that accepts the write, so a read in the following cycle shows the cleared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 64 | Per-channel set strobes |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Write byte-lane strobes |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| flags_o | output | 64 | Current flag vector |

## Verification
A hardware set and a software clear can reach the same flag on the same edge. The bench provokes this by raising one strobe while it writes that channel's clear command. It also raises a strobe pattern while it writes a clear-all command. After the edge it reads both words back and compares them with the strobe pattern ORed into what the clear alone would leave. A correct design keeps every struck flag set.

// File: rtl/chan_flag_idxclr.sv
module chan_flag_idxclr #(
  parameter int NCH  = 64,
  parameter int DW   = 32,
  parameter int AW   = 4,
  parameter int CMDW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  set_i,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic [DW/8-1:0] bus_wstrb,
  output logic [DW-1:0]   bus_rdata,
  output logic [NCH-1:0]  flags_o
);
  localparam int HALVES = NCH / DW;
  localparam int IDXW   = $clog2(NCH);
  localparam int FLDW   = CMDW - 1;
  localparam int WIW    = AW - 2;

  logic [NCH-1:0] flags_q, clr_mask;
  wire  [WIW-1:0] word_idx = bus_addr[AW-1:2];
  wire            cmd_hit  = bus_valid & bus_write & (word_idx == WIW'(HALVES)) & bus_wstrb[0];
  wire  [FLDW-1:0] cmd     = bus_wdata[FLDW-1:0];
  wire            clr_all  = cmd[FLDW-1];
  wire  [IDXW-1:0] idx     = cmd[IDXW-1:0];

  always_comb begin
    clr_mask = '0;
    if (cmd_hit) begin
      if (clr_all) clr_mask = '1;
      else         clr_mask[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_mask) | set_i;

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write)
      for (int h = 0; h < HALVES; h++)
        if (word_idx == WIW'(h)) bus_rdata = flags_q[h*DW +: DW];
  end

  assign flags_o = flags_q;

  wire unused_ok = ^{bus_addr[1:0], bus_wdata[DW-1:FLDW], bus_wstrb[DW/8-1:1]};
endmodule

// File: rtl/chk_chan_flag_idxclr.sv
module chk_chan_flag_idxclr #(
  parameter int NCH = 64,
  parameter int DW  = 32,
  parameter int AW  = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  set_i,
  input logic            bus_valid,
  input logic            bus_write,
  input logic [AW-1:0]   bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW/8-1:0] bus_wstrb,
  input logic [DW-1:0]   bus_rdata,
  input logic [NCH-1:0]  flags_o
);
  wire       at_cmd  = bus_addr[AW-1:2] == 2'd2;
  wire       wr_cmd  = bus_valid & bus_write & at_cmd & bus_wstrb[0];
  wire [5:0] ch      = bus_wdata[5:0];
  wire       one_clr = wr_cmd & ~bus_wdata[6];
  wire       all_clr = wr_cmd &  bus_wdata[6];
  wire       hit_set = set_i[ch];
  wire       wr_flag = bus_valid & bus_write & !at_cmd;

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> flags_o == '0); // R1
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i != '0 |=> (flags_o & $past(set_i)) == $past(set_i)); // R2
  AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    one_clr && !hit_set |=> !flags_o[$past(ch)]); // R3
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    all_clr |=> flags_o == $past(set_i)); // R4
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    one_clr && hit_set |=> flags_o[$past(ch)]); // R6
  AST_CMD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && at_cmd |-> bus_rdata == '0); // R8
  AST_FLAG_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_flag |=> flags_o == ($past(flags_o) | $past(set_i))); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_n || 1'b1 |=> (flags_o & ~$past(flags_o) & ~$past(set_i)) == '0); // R2
endmodule

bind chan_flag_idxclr chk_chan_flag_idxclr #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (.*);

// File: tb/sim_chan_flag_idxclr.sv
module sim_chan_flag_idxclr;
  logic        clk = 0, rst_n = 0;
  logic [63:0] set_i = '0;
  logic        bus_valid = 0, bus_write = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic [63:0] flags_o;
  int errors = 0, checks = 0;

  chan_flag_idxclr u0 (.*);

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s, input logic [63:0] sv);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s; set_i = sv;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wstrb = '0; set_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(4'h0, lo);
    rd(4'h4, hi);
    v = {hi, lo};
  endtask

  task automatic set_all();
    @(negedge clk); set_i = '1;
    @(negedge clk); set_i = '0;
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] v, exp;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd64(v);
    check(v == '0 && flags_o == '0, "R1 reset state", v, 64'h0);

    for (int k = 0; k < 64; k += 7) begin
      exp = 64'h1 << k;
      wr(4'h8, 32'h40, 4'h1, '0);
      @(negedge clk); set_i = exp;
      @(negedge clk); set_i = '0;
      repeat (2) @(negedge clk);
      rd64(v);
      check(v == exp, "R2/R7 set strobe sticks, half mapping", v, exp);
    end

    for (int c = 0; c < 256; c++) begin
      set_all();
      wr(4'h8, {24'hA5C3E1, 8'(c)}, 4'h1, '0);
      exp = ((c & 127) < 64) ? ~(64'h1 << (c & 127)) : 64'h0;
      rd64(v);
      check(v == exp, (c > 127) ? "R5 reserved bit ignored" :
            ((c < 64) ? "R3/R11 single clear" : "R4/R11 clear all"), v, exp);
    end

    for (int k = 0; k < 64; k++) begin
      set_all();
      wr(4'h8, 32'(k), 4'h1, 64'h1 << k);
      rd64(v);
      check(v == '1, "R6 set wins over single clear", v, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    set_all();
    wr(4'h8, 32'h7F, 4'h1, 64'h8000_0001_0F00_0003);
    rd64(v);
    check(v == 64'h8000_0001_0F00_0003, "R6 set wins over clear all", v, 64'h8000_0001_0F00_0003);

    set_all();
    wr(4'h8, 32'h40, 4'h1, '0);
    rd(4'h8, w);
    check(w == 0, "R8 command reads zero", 64'(w), 64'h0);
    wr(4'h8, 32'hFFFF_FF05, 4'h1, '0);
    rd(4'h8, w);
    check(w == 0, "R8 command reads zero after write", 64'(w), 64'h0);

    set_all();
    wr(4'h0, 32'h0, 4'hF, '0);
    wr(4'h4, 32'h0, 4'hF, '0);
    wr(4'h0, 32'h40, 4'hF, '0);
    rd64(v);
    check(v == '1, "R9 flag words read-only", v, 64'hFFFF_FFFF_FFFF_FFFF);

    for (int s = 0; s < 16; s += 2) begin
      set_all();
      wr(4'h8, 32'h4040_4040, 4'(s), '0);
      rd64(v);
      check(v == '1, "R10 lane 0 strobe required", v, 64'hFFFF_FFFF_FFFF_FFFF);
    end
    set_all();
    wr(4'h8, 32'hFFFF_FF21, 4'h1, '0);
    rd64(v);
    exp = ~(64'h1 << 33);
    check(v == exp, "R10 upper lanes ignored", v, exp);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule